// File: doc/BRIEF.md
# Power-Down Entry and Wake Controller

This block decides whether a request to stop the clocks may be honoured, stops the oscillator and PLL when it is, and sequences the return to normal operation. It has two sleep flavours, picked by a mode bit at the moment of the request. In the guarded flavour, the sleep is accepted only while the non-maskable interrupt pin is held low, and only a hardware reset ends it. In the wakeable flavour, eight external pins, each governed by a 2-bit selector, decide both whether sleep is allowed and what ends it.

After a wake, the oscillator and PLL restart at once. The controller then switches on a weak pull-down on an external delay pin, which has a capacitor on it. CPU and peripheral clocks stay gated until the digitised level of that pin reads low, so the capacitor sets the time the oscillator has to settle. The block runs from an always-on sampling clock. A pin condition is accepted only after it has been seen on a parameterised number of consecutive sampling edges, which covers the minimum pulse width of about 40 ns.

Top module: `pdc_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `clk_en` is 1, and `osc_stop`, `dly_pulldown`, `pd_entered` and `pd_rejected` are all 0.
- R2: Guarded flavour (`pd_mode`=0): a `pd_req` sampled while `nmi_n` is 0 raises `pd_entered` for exactly one cycle. In that same cycle `osc_stop` goes to 1 and `clk_en` goes to 0.
- R3: A `pd_req` whose entry condition fails is dropped. `pd_rejected` pulses for one cycle and the clock outputs stay in the running state.
- R4: A sleep entered in the guarded flavour is never ended by any activity on `ext_pin`.
- R5: Wakeable flavour (`pd_mode`=1): pin i is controlled by `edge_sel[2i+1:2i]`. Code 0 places no condition on entry. Code 1 needs the pin at 0. Code 2 needs the pin at 1. Code 3 always allows entry. Entry happens only if every pin allows it.
- R6: In a wakeable sleep, pin i is active under these conditions. Code 1: the pin is 1. Code 2: the pin is 0. Code 3: the pin differs from the level it had when the request was accepted. Code 0: never active. Pin levels and codes are captured when the request is accepted.
- R7: A pin condition ends the sleep only after it has held for `WAKE_HOLD` consecutive sampling edges (default 3). A shorter active spell has no effect.
- R8: After a wake, `osc_stop` is 0, `dly_pulldown` is 1 and `clk_en` is 0. This lasts until `dly_pin` is sampled at 0. On the next cycle `clk_en` returns to 1 and `dly_pulldown` returns to 0.
- R9: `pd_req` is ignored outside the running state. It produces no status pulse and no state change.
- R10: `rst` returns the block to the running state from sleep or from the settling phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sampling clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| pd_req | input | 1 | One-cycle sleep request strobe |
| pd_mode | input | 1 | 0 = guarded flavour, 1 = wakeable flavour |
| nmi_n | input | 1 | Non-maskable interrupt pin level |
| ext_pin | input | 8 | External wake pin levels |
| edge_sel | input | 16 | Two-bit selector per pin, pin i at bits [2i+1:2i] |
| dly_pin | input | 1 | Digitised level of the delay pin |
| osc_stop | output | 1 | Stop oscillator and PLL |
| clk_en | output | 1 | Enable CPU and peripheral clocks |
| dly_pulldown | output | 1 | Enable the weak pull-down on the delay pin |
| pd_entered | output | 1 | One-cycle pulse when a sleep begins |
| pd_rejected | output | 1 | One-cycle pulse when a request is dropped |

## Verification
Most internal faults show up within a cycle or two as a wrong clock output. A wrong entry decision shows on the cycle after the strobe, as a swapped `pd_entered`/`pd_rejected` pulse together with a running or stopped `osc_stop`. A wrong wake filter count makes the settle phase start one edge early or late, or not at all. A corrupted captured level or selector makes the code-3 pin wake on the wrong transition. Faults in the settle phase appear as `clk_en` rising before `dly_pin` falls, or as `dly_pulldown` staying on after the clocks return.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

    typedef enum logic [1:0] {
        PD_RUN    = 2'd0,
        PD_SLEEP  = 2'd1,
        PD_SETTLE = 2'd2
    } pd_state_e;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'd0,
        SEL_HIGH = 2'd1,
        SEL_LOW  = 2'd2,
        SEL_ANY  = 2'd3
    } pin_sel_e;

    typedef struct packed {
        logic osc_stop;
        logic clk_en;
        logic pull_dn;
    } clk_ctl_t;

    // may a pin with this selector permit entry at this level
    function automatic logic pin_entry_ok(pin_sel_e sel, logic lvl);
        case (sel)
            SEL_HIGH: return !lvl;
            SEL_LOW:  return lvl;
            default:  return 1'b1;
        endcase
    endfunction

    // is the pin asking to wake, given level captured at entry
    function automatic logic pin_wake(pin_sel_e sel, logic lvl, logic ref_lvl);
        case (sel)
            SEL_HIGH: return lvl;
            SEL_LOW:  return !lvl;
            SEL_ANY:  return lvl != ref_lvl;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic clk_ctl_t ctl_of(pd_state_e st);
        clk_ctl_t c;
        c.osc_stop = (st == PD_SLEEP);
        c.clk_en   = (st == PD_RUN);
        c.pull_dn  = (st == PD_SETTLE);
        return c;
    endfunction

endpackage

// File: rtl/pdc_entry_check.sv
module pdc_entry_check
    import pdc_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic [N_PINS-1:0]   pins,
    input  logic [2*N_PINS-1:0] sel,
    output logic                all_ok
);
    logic [N_PINS-1:0] ok;

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            assign ok[i] = pin_entry_ok(pin_sel_e'(sel[2*i +: 2]), pins[i]);
        end
    endgenerate

    assign all_ok = &ok;
endmodule

// File: rtl/pdc_wake_filter.sv
module pdc_wake_filter
    import pdc_pkg::*;
#(
    parameter int N_PINS   = 8,
    parameter int WAKE_HOLD = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic                capture,
    input  logic [N_PINS-1:0]   pins,
    input  logic [2*N_PINS-1:0] sel,
    output logic                wake
);
    localparam int          CW   = $clog2(WAKE_HOLD + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_HOLD - 1);

    logic [N_PINS-1:0] hit;

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            logic          ref_q;
            pin_sel_e      sel_q;
            logic [CW-1:0] cnt_q;
            logic          act;

            always_ff @(posedge clk) begin
                if (rst) begin
                    ref_q <= 1'b0;
                    sel_q <= SEL_OFF;
                end else if (capture) begin
                    ref_q <= pins[i];
                    sel_q <= pin_sel_e'(sel[2*i +: 2]);
                end
            end

            assign act = pin_wake(sel_q, pins[i], ref_q);

            always_ff @(posedge clk) begin
                if (rst || !arm || !act)
                    cnt_q <= '0;
                else if (cnt_q != LAST)
                    cnt_q <= cnt_q + CW'(1);
            end

            assign hit[i] = arm && act && (cnt_q == LAST);
        end
    endgenerate

    assign wake = |hit;
endmodule

// File: rtl/pdc_fsm.sv
module pdc_fsm
    import pdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pd_req,
    input  logic      pd_mode,
    input  logic      nmi_n,
    input  logic      pins_ok,
    input  logic      wake,
    input  logic      dly_pin,
    output clk_ctl_t  ctl,
    output logic      capture,
    output logic      armed,
    output logic      guarded_q,
    output logic      entered,
    output logic      rejected
);
    pd_state_e st_q;
    logic      cond_ok;

    assign cond_ok = pd_mode ? pins_ok : !nmi_n;
    assign capture = (st_q == PD_RUN) && pd_req && cond_ok;
    assign armed   = (st_q == PD_SLEEP) && !guarded_q;
    assign ctl     = ctl_of(st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= PD_RUN;
            guarded_q <= 1'b0;
            entered   <= 1'b0;
            rejected  <= 1'b0;
        end else begin
            entered  <= 1'b0;
            rejected <= 1'b0;
            case (st_q)
                PD_RUN: begin
                    if (pd_req) begin
                        if (cond_ok) begin
                            st_q      <= PD_SLEEP;
                            guarded_q <= !pd_mode;
                            entered   <= 1'b1;
                        end else begin
                            rejected  <= 1'b1;
                        end
                    end
                end
                PD_SLEEP: begin
                    if (wake && !guarded_q)
                        st_q <= PD_SETTLE;
                end
                PD_SETTLE: begin
                    if (!dly_pin)
                        st_q <= PD_RUN;
                end
                default: st_q <= PD_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
    import pdc_pkg::*;
#(
    parameter int N_PINS    = 8,
    parameter int WAKE_HOLD = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pd_req,
    input  logic                pd_mode,
    input  logic                nmi_n,
    input  logic [N_PINS-1:0]   ext_pin,
    input  logic [2*N_PINS-1:0] edge_sel,
    input  logic                dly_pin,
    output logic                osc_stop,
    output logic                clk_en,
    output logic                dly_pulldown,
    output logic                pd_entered,
    output logic                pd_rejected
);
    clk_ctl_t ctl;
    logic     pins_ok, wake, capture, armed, guarded_q;

    pdc_entry_check #(.N_PINS(N_PINS)) u_entry (
        .pins   (ext_pin),
        .sel    (edge_sel),
        .all_ok (pins_ok)
    );

    pdc_wake_filter #(.N_PINS(N_PINS), .WAKE_HOLD(WAKE_HOLD)) u_wake (
        .clk     (clk),
        .rst     (rst),
        .arm     (armed),
        .capture (capture),
        .pins    (ext_pin),
        .sel     (edge_sel),
        .wake    (wake)
    );

    pdc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pd_req    (pd_req),
        .pd_mode   (pd_mode),
        .nmi_n     (nmi_n),
        .pins_ok   (pins_ok),
        .wake      (wake),
        .dly_pin   (dly_pin),
        .ctl       (ctl),
        .capture   (capture),
        .armed     (armed),
        .guarded_q (guarded_q),
        .entered   (pd_entered),
        .rejected  (pd_rejected)
    );

    assign osc_stop     = ctl.osc_stop;
    assign clk_en       = ctl.clk_en;
    assign dly_pulldown = ctl.pull_dn;
endmodule

// File: rtl/pdc_ctrl_chk.sv
module pdc_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic dly_pin,
    input logic osc_stop,
    input logic clk_en,
    input logic dly_pulldown,
    input logic pd_entered,
    input logic pd_rejected,
    input logic guarded_q
);
    a_r2_stop_gates_clocks: assert property (@(posedge clk) disable iff (rst)
        osc_stop |-> !clk_en);

    a_r2_sleep_starts_with_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_stop) |-> pd_entered);

    a_r2_entered_single: assert property (@(posedge clk) disable iff (rst)
        pd_entered |=> !pd_entered);

    a_r3_reject_keeps_running: assert property (@(posedge clk) disable iff (rst)
        pd_rejected |-> (clk_en && !osc_stop));

    a_r4_guarded_holds: assert property (@(posedge clk) disable iff (rst)
        (osc_stop && guarded_q) |=> osc_stop);

    a_r8_settle_from_sleep: assert property (@(posedge clk) disable iff (rst)
        $rose(dly_pulldown) |-> $past(osc_stop));

    a_r8_pulldown_excl: assert property (@(posedge clk) disable iff (rst)
        dly_pulldown |-> (!clk_en && !osc_stop));

    a_r8_resume_on_low: assert property (@(posedge clk) disable iff (rst)
        (dly_pulldown && !dly_pin) |=> clk_en);
endmodule

bind pdc_ctrl pdc_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .dly_pin      (dly_pin),
    .osc_stop     (osc_stop),
    .clk_en       (clk_en),
    .dly_pulldown (dly_pulldown),
    .pd_entered   (pd_entered),
    .pd_rejected  (pd_rejected),
    .guarded_q    (guarded_q)
);

// File: tb/pdc_ctrl_test.sv
module pdc_ctrl_test;
    localparam int PERIOD = 10;
    localparam int HOLD   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pd_req = 1'b0, pd_mode = 1'b0, nmi_n = 1'b1, dly_pin = 1'b1;
    logic [7:0]  ext_pin = '0;
    logic [15:0] edge_sel = '0;
    logic        osc_stop, clk_en, dly_pulldown, pd_entered, pd_rejected;

    int    n_checks = 0;
    int    n_err = 0;
    string tag = "R1";

    // reference model state
    int   m_st = 0;          // 0 run, 1 sleep, 2 settle
    bit   m_prot = 0, m_ent = 0, m_rej = 0;
    bit   m_ref[8];
    int   m_sel[8];
    int   m_cnt[8];

    always #(PERIOD/2) clk = ~clk;

    pdc_ctrl uut (
        .clk(clk), .rst(rst), .pd_req(pd_req), .pd_mode(pd_mode), .nmi_n(nmi_n),
        .ext_pin(ext_pin), .edge_sel(edge_sel), .dly_pin(dly_pin),
        .osc_stop(osc_stop), .clk_en(clk_en), .dly_pulldown(dly_pulldown),
        .pd_entered(pd_entered), .pd_rejected(pd_rejected)
    );

    always @(posedge clk) begin
        bit ok, hit, act;
        int code;
        m_ent = 0;
        m_rej = 0;
        if (rst) begin
            m_st = 0;
            m_prot = 0;
            for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        end else if (m_st == 0) begin
            if (pd_req) begin
                ok = 1;
                if (!pd_mode) ok = !nmi_n;
                else for (int i = 0; i < 8; i++) begin
                    code = int'(edge_sel[2*i +: 2]);
                    if (code == 1 && ext_pin[i]) ok = 0;
                    if (code == 2 && !ext_pin[i]) ok = 0;
                end
                if (ok) begin
                    m_st = 1; m_ent = 1; m_prot = !pd_mode;
                    for (int i = 0; i < 8; i++) begin
                        m_ref[i] = ext_pin[i];
                        m_sel[i] = int'(edge_sel[2*i +: 2]);
                        m_cnt[i] = 0;
                    end
                end else m_rej = 1;
            end
        end else if (m_st == 1) begin
            if (!m_prot) begin
                hit = 0;
                for (int i = 0; i < 8; i++) begin
                    act = (m_sel[i] == 1 && ext_pin[i]) || (m_sel[i] == 2 && !ext_pin[i])
                       || (m_sel[i] == 3 && ext_pin[i] != m_ref[i]);
                    if (!act) m_cnt[i] = 0;
                    else if (m_cnt[i] == HOLD - 1) hit = 1;
                    else m_cnt[i]++;
                end
                if (hit) begin
                    m_st = 2;
                    for (int i = 0; i < 8; i++) m_cnt[i] = 0;
                end
            end
        end else begin
            if (!dly_pin) m_st = 0;
        end
    end

    task automatic chk(string name, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("clk_en", clk_en, m_st == 0);
            chk("osc_stop", osc_stop, m_st == 1);
            chk("dly_pulldown", dly_pulldown, m_st == 2);
            chk("pd_entered", pd_entered, m_ent);
            chk("pd_rejected", pd_rejected, m_rej);
            pd_req = 1'b0;
        end
    endtask

    task automatic request();
        pd_req = 1'b1;
        step(1);
    endtask

    task automatic expect_state(string what, int st);
        n_checks++;
        if (m_st != st) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, m_st, st);
        end
    endtask

    initial begin
        #(PERIOD * 20000);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
        $finish;
    end

    initial begin
        tag = "R1";
        step(2);
        rst = 1'b0;
        step(2);
        expect_state("running after reset R1", 0);

        tag = "R3";                 // guarded, nmi high -> dropped
        pd_mode = 1'b0; nmi_n = 1'b1;
        request(); step(2);
        expect_state("reject keeps run R3", 0);

        tag = "R2";
        nmi_n = 1'b0;
        request(); step(1);
        expect_state("guarded sleep R2", 1);

        tag = "R4";                 // pins cannot wake a guarded sleep
        nmi_n = 1'b1; edge_sel = 16'h5555;
        ext_pin = 8'hFF; step(6);
        ext_pin = 8'h00; step(3);
        expect_state("guarded stays asleep R4", 1);

        tag = "R9";
        request(); step(2);
        expect_state("request ignored in sleep R9", 1);

        tag = "R10";
        rst = 1'b1; step(1); rst = 1'b0; step(1);
        expect_state("reset exits sleep R10", 0);

        tag = "R5";                 // pin0 code 1 needs pin low
        pd_mode = 1'b1; edge_sel = 16'h0001; ext_pin = 8'h01;
        request(); step(1);
        expect_state("code1 high blocks R5", 0);
        ext_pin = 8'hFE;            // code 0 pins high are irrelevant
        request(); step(1);
        expect_state("code1 low admits R5", 1);

        tag = "R7";                 // short pulse filtered
        ext_pin = 8'hFF; step(HOLD - 1);
        ext_pin = 8'hFE; step(3);
        expect_state("short pulse filtered R7", 1);

        tag = "R6";
        ext_pin = 8'hFF; step(HOLD);
        expect_state("code1 wake R6", 2);

        tag = "R8";
        dly_pin = 1'b1; step(5);
        dly_pin = 1'b0; step(2);
        expect_state("clocks back R8", 0);
        dly_pin = 1'b1;

        tag = "R5";                 // pin3 code 2 needs pin high
        edge_sel = 16'h0080; ext_pin = 8'h00;
        request(); step(1);
        ext_pin = 8'h08;
        request(); step(1);
        expect_state("code2 admits R5", 1);
        tag = "R6";
        ext_pin = 8'h00; step(HOLD + 1);
        expect_state("code2 wake R6", 2);
        tag = "R10";
        step(2); rst = 1'b1; step(1); rst = 1'b0; step(1);
        expect_state("reset exits settle R10", 0);

        tag = "R6";                 // pin5 code 3 wakes on change; code 0 toggles ignored
        edge_sel = 16'h0C00; ext_pin = 8'h20;
        request(); step(1);
        ext_pin = 8'h3F; step(4);
        ext_pin = 8'h00; step(HOLD - 1);
        expect_state("code3 not yet R6", 1);
        step(1);
        expect_state("code3 change wakes R6", 2);
        tag = "R8";
        dly_pin = 1'b0; step(3);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule